// File: doc/BRIEF.md
# Interrupt Destination Router

This block turns a set of pending interrupt sources into per-core, per-line interrupt requests. Each source arrives with a pending bit and a routing-table index. A small table holds one entry per index. Each entry names a processor interrupt line and a bitmask of target cores. Every cycle, the block scans the pending sources through the table. For every (core, line) pair it records the lowest-numbered source that targets that pair. The results sit in a bank of destination registers, one per pair. The valid flag of each register drives the matching processor interrupt pin.

Software programs the table and reads the destination registers through a simple register port. Writes take one cycle and reads are combinational. Each core owns four consecutive table entries, starting at 4 × core + 1, because index 0 is never used for routing. The destination register for a core and line sits at slot 3 × core + line. An interrupt handler reads its slot to learn which source to service. A clear valid flag tells the handler that there is nothing to service.

Top module: `irq_dest_router`

## Requirements
- R1: After reset, every table entry and every destination register reads zero, and all interrupt pins are low.
- R2: The entry line field lives in bits [1:0] at address 0x110000 + index × 8. Values 0, 1 and 2 select line 0, 1 and 2. Value 3 selects no line, so the entry routes nothing.
- R3: The core mask of an entry lives in bits [NUM_CORES-1:0] at address 0x120000 + index × 32. The three other 8-byte words in that 32-byte group read zero and ignore writes. A mask of zero routes the entry to no core.
- R4: Index 0 is reserved, and so is any index of 4 × NUM_CORES + 1 or above. Writes to entry 0 are ignored and entry 0 reads zero. A source that carries a reserved index is never routed.
- R5: A pending source whose entry has line L and core-mask bit c set is delivered to slot 3 × c + L. This holds for every set mask bit, so one source can reach several cores at once.
- R6: The destination register for slot s is read at 0x200000 + s × 8. Bit 63 is the valid flag and bits [19:0] hold the source number; source input i has number i. All other bits read zero. When nothing is routed to the slot, the whole register reads zero, which marks a spurious interrupt.
- R7: When several pending sources reach the same slot, the lowest-numbered one is reported.
- R8: Destination registers capture the routing of the previous cycle. A slot goes clear in the cycle after its last source stops pending.
- R9: Interrupt pin s is high exactly when the valid flag of destination register s is set.
- R10: The I/O target words at 0x130000 + index × 8 always read zero, and writes to them change nothing.
- R11: Destination registers are read-only: a write to one leaves its contents unchanged.
- R12: A table write takes effect in the cycle after the write. The destination update at the same clock edge as the write still uses the entry's previous contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_pend | input | NUM_SRC | Pending flag per source; bit i is source number i |
| src_idx | input | NUM_SRC × IDX_W | Routing-table index per source; source i uses bits [i×IDX_W +: IDX_W] |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from reg_addr |
| cpu_irq | output | 3 × NUM_CORES | Interrupt pin per slot; bit 3 × core + line |

## Verification
Two functions can fall in the same clock edge: a table entry can be rewritten while a pending source is being routed through that entry. The bench provokes this directly. It holds a source pending on an entry and, in the same cycle, rewrites that entry's line and mask. It also lets the random phase mix table writes with pending traffic. The bench model judges each such cycle by routing with the entry contents from before the write, then expects the new routing from the following cycle onward.

// File: rtl/irq_dest_router.sv
module irq_dest_router #(
  parameter int NUM_CORES = 4,
  parameter int NUM_SRC   = 32,
  parameter int SRC_NUM_W = 20,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  localparam int IDX_W    = $clog2(4*NUM_CORES+1),
  localparam int NUM_SLOT = 3*NUM_CORES
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_SRC-1:0]       src_pend,
  input  logic [NUM_SRC*IDX_W-1:0] src_idx,
  input  logic                     reg_wr,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [DATA_W-1:0]        reg_wdata,
  output logic [DATA_W-1:0]        reg_rdata,
  output logic [NUM_SLOT-1:0]      cpu_irq
);
  localparam int NUM_ENT = 4*NUM_CORES+1;
  localparam int SLOT_W  = $clog2(NUM_SLOT);
  localparam logic [ADDR_W-1:0] CTL_BASE = ADDR_W'('h110000);
  localparam logic [ADDR_W-1:0] MSK_BASE = ADDR_W'('h120000);
  localparam logic [ADDR_W-1:0] DST_BASE = ADDR_W'('h200000);

  logic [1:0]           ent_line [NUM_ENT];
  logic [NUM_CORES-1:0] ent_mask [NUM_ENT];

  logic [NUM_SLOT-1:0]                dst_vld, nxt_vld;
  logic [NUM_SLOT-1:0][SRC_NUM_W-1:0] dst_num, nxt_num;

  logic [ADDR_W-1:0] ctl_off, msk_off, dst_off;
  logic              in_ctl, in_msk, in_dst;
  logic [IDX_W-1:0]  ctl_idx, msk_idx;
  logic [1:0]        msk_sub;
  logic [SLOT_W-1:0] dst_slot;

  assign ctl_off  = reg_addr - CTL_BASE;
  assign msk_off  = reg_addr - MSK_BASE;
  assign dst_off  = reg_addr - DST_BASE;
  assign in_ctl   = (reg_addr >= CTL_BASE) && (ctl_off < ADDR_W'(NUM_ENT*8));
  assign in_msk   = (reg_addr >= MSK_BASE) && (msk_off < ADDR_W'(NUM_ENT*32));
  assign in_dst   = (reg_addr >= DST_BASE) && (dst_off < ADDR_W'(NUM_SLOT*8));
  assign ctl_idx  = ctl_off[IDX_W+2:3];
  assign msk_idx  = msk_off[IDX_W+4:5];
  assign msk_sub  = msk_off[4:3];
  assign dst_slot = dst_off[SLOT_W+2:3];

  wire unused_bits = ^{reg_wdata, reg_addr[2:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_ENT; k++) begin
        ent_line[k] <= '0;
        ent_mask[k] <= '0;
      end
    end else if (reg_wr) begin
      if (in_ctl && ctl_idx != '0)
        ent_line[ctl_idx] <= reg_wdata[1:0];
      if (in_msk && msk_sub == 2'd0 && msk_idx != '0)
        ent_mask[msk_idx] <= reg_wdata[NUM_CORES-1:0];
    end
  end

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    localparam int         CORE = s / 3;
    localparam logic [1:0] LINE = 2'(s % 3);
    logic                 v;
    logic [SRC_NUM_W-1:0] n;

    always_comb begin
      logic [IDX_W-1:0] e;
      v = 1'b0;
      n = '0;
      e = '0;
      for (int i = NUM_SRC-1; i >= 0; i--) begin
        e = src_idx[i*IDX_W +: IDX_W];
        if (src_pend[i] && e != '0 && e < IDX_W'(NUM_ENT) &&
            ent_line[e] == LINE && ent_mask[e][CORE]) begin
          v = 1'b1;
          n = SRC_NUM_W'(i);
        end
      end
    end

    assign nxt_vld[s] = v;
    assign nxt_num[s] = n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dst_vld <= '0;
      dst_num <= '0;
    end else begin
      dst_vld <= nxt_vld;
      dst_num <= nxt_num;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (in_ctl)
      reg_rdata[1:0] = ent_line[ctl_idx];
    else if (in_msk && msk_sub == 2'd0)
      reg_rdata[NUM_CORES-1:0] = ent_mask[msk_idx];
    else if (in_dst) begin
      reg_rdata[DATA_W-1]      = dst_vld[dst_slot];
      reg_rdata[SRC_NUM_W-1:0] = dst_num[dst_slot];
    end
  end

  assign cpu_irq = dst_vld;
endmodule

// File: rtl/irq_dest_router_chk.sv
module irq_dest_router_chk #(
  parameter int NUM_CORES = 4,
  parameter int NUM_SRC   = 32,
  parameter int SRC_NUM_W = 20,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  localparam int NUM_SLOT = 3*NUM_CORES
) (
  input logic                               clk,
  input logic                               rst,
  input logic [NUM_SRC-1:0]                 src_pend,
  input logic [ADDR_W-1:0]                  reg_addr,
  input logic [DATA_W-1:0]                  reg_rdata,
  input logic [NUM_SLOT-1:0]                cpu_irq,
  input logic [NUM_SLOT-1:0]                dst_vld,
  input logic [NUM_SLOT-1:0][SRC_NUM_W-1:0] dst_num
);
  localparam int NUM_ENT = 4*NUM_CORES+1;
  localparam logic [ADDR_W-1:0] CTL_BASE = ADDR_W'('h110000);
  localparam logic [ADDR_W-1:0] IOT_BASE = ADDR_W'('h130000);
  localparam logic [ADDR_W-1:0] DST_BASE = ADDR_W'('h200000);

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> cpu_irq == '0);

  p_quiet_next_r8: assert property (@(posedge clk) disable iff (rst)
    src_pend == '0 |=> cpu_irq == '0);

  p_reserved_zero_r4: assert property (@(posedge clk) disable iff (rst)
    reg_addr == CTL_BASE |-> reg_rdata == '0);

  p_io_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_addr >= IOT_BASE && reg_addr < IOT_BASE + ADDR_W'(NUM_ENT*8)) |-> reg_rdata == '0);

  p_dst_format_r6: assert property (@(posedge clk) disable iff (rst)
    (reg_addr >= DST_BASE && reg_addr < DST_BASE + ADDR_W'(NUM_SLOT*8))
      |-> reg_rdata[DATA_W-2:SRC_NUM_W] == '0);

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_chk
    p_num_was_pending_r7: assert property (@(posedge clk) disable iff (rst)
      dst_vld[s] |-> (($past(src_pend) >> dst_num[s]) & NUM_SRC'(1)) != '0);
  end
endmodule

bind irq_dest_router irq_dest_router_chk #(
  .NUM_CORES(NUM_CORES), .NUM_SRC(NUM_SRC), .SRC_NUM_W(SRC_NUM_W),
  .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .src_pend(src_pend), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .cpu_irq(cpu_irq), .dst_vld(dst_vld), .dst_num(dst_num)
);

// File: tb/irq_dest_router_tb_top.sv
`timescale 1ns/10ps
module irq_dest_router_tb_top;
  localparam int NC = 4, NS = 32, IW = 5, NSL = 12, NE = 17;

  logic clk = 1'b0, rst = 1'b1;
  logic [NS-1:0]    src_pend = '0;
  logic [NS*IW-1:0] src_idx = '0;
  logic             reg_wr = 1'b0;
  logic [31:0]      reg_addr = '0;
  logic [63:0]      reg_wdata = '0, reg_rdata;
  logic [NSL-1:0]   cpu_irq;

  irq_dest_router dut_i (.clk(clk), .rst(rst), .src_pend(src_pend), .src_idx(src_idx),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cpu_irq(cpu_irq));

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [1:0]    m_line [NE];
  logic [NC-1:0] m_mask [NE];
  logic [NSL-1:0] e_vld;
  logic [19:0]    e_num [NSL];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic route();
    for (int s = 0; s < NSL; s++) begin
      e_vld[s] = 1'b0; e_num[s] = '0;
      for (int i = NS-1; i >= 0; i--) begin
        int e = int'(src_idx[i*IW +: IW]);
        if (src_pend[i] && e > 0 && e < NE && int'(m_line[e]) == s % 3 && m_mask[e][s/3]) begin
          e_vld[s] = 1'b1; e_num[s] = 20'(i);
        end
      end
    end
  endtask

  task automatic model_write(input logic [31:0] a, input logic [63:0] d);
    if (a >= 32'h110000 && a < 32'h110000 + NE*8 && ((a - 32'h110000) >> 3) != 0)
      m_line[(a - 32'h110000) >> 3] = d[1:0];
    if (a >= 32'h120000 && a < 32'h120000 + NE*32 && ((a - 32'h120000) >> 5) != 0
        && (((a - 32'h120000) >> 3) & 3) == 0)
      m_mask[(a - 32'h120000) >> 5] = d[NC-1:0];
  endtask

  task automatic cycle(input logic [NS-1:0] p, input logic [NS*IW-1:0] ix,
                       input logic wr, input logic [31:0] a, input logic [63:0] d,
                       input string tag);
    @(negedge clk);
    src_pend = p; src_idx = ix; reg_wr = wr; reg_addr = a; reg_wdata = d;
    route();
    if (wr) model_write(a, d);
    @(posedge clk);
    #1 reg_wr = 1'b0;
    chk({tag, " R9 pins"}, 64'(cpu_irq), 64'(e_vld));
    for (int s = 0; s < NSL; s++) begin
      reg_addr = 32'h200000 + 32'(s*8);
      #0.2;
      chk({tag, " R6 dest"}, reg_rdata, {e_vld[s], 43'd0, e_num[s]});
    end
  endtask

  task automatic rd(input logic [31:0] a, input logic [63:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1 chk(tag, reg_rdata, exp);
  endtask

  function automatic logic [NS*IW-1:0] one_idx(input int src, input int e);
    logic [NS*IW-1:0] r = '0;
    r[src*IW +: IW] = IW'(e);
    return r;
  endfunction

  initial begin
    #(8*200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [NS*IW-1:0] ix;
    logic [NS-1:0] p;
    void'($urandom(32'd1234));
    for (int k = 0; k < NE; k++) begin m_line[k] = '0; m_mask[k] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1 chk("R1 pins", 64'(cpu_irq), 64'd0);
    rd(32'h200000, 64'd0, "R1 dest0");
    rd(32'h110000 + 8*6, 64'd0, "R1 line6");
    rd(32'h120000 + 32*6, 64'd0, "R1 mask6");

    cycle('0, '0, 1, 32'h110000 + 8*1, 64'd0, "cfg");
    cycle('0, '0, 1, 32'h120000 + 32*1, 64'h1, "cfg");
    cycle('0, '0, 1, 32'h110000 + 8*2, 64'd1, "cfg");
    cycle('0, '0, 1, 32'h120000 + 32*2, 64'h3, "cfg");
    cycle('0, '0, 1, 32'h110000 + 8*5, 64'd0, "cfg");
    cycle('0, '0, 1, 32'h120000 + 32*5, 64'h2, "cfg");
    cycle('0, '0, 1, 32'h110000 + 8*6, 64'd2, "cfg");
    cycle('0, '0, 1, 32'h120000 + 32*6, 64'hC, "cfg");
    cycle('0, '0, 1, 32'h110000 + 8*9, 64'd3, "cfg");
    cycle('0, '0, 1, 32'h120000 + 32*9, 64'hF, "cfg");
    cycle('0, '0, 1, 32'h120000 + 32*13, 64'h0, "cfg");
    rd(32'h110000 + 8*2, 64'd1, "R2 line readback");
    rd(32'h120000 + 32*6, 64'hC, "R3 mask readback");
    cycle('0, '0, 1, 32'h120000 + 32*2 + 8, 64'hF, "R3 sub write");
    rd(32'h120000 + 32*2 + 8, 64'd0, "R3 sub reads zero");
    rd(32'h120000 + 32*2, 64'h3, "R3 mask kept");
    cycle('0, '0, 1, 32'h130000 + 8*3, 64'hFFFF, "R10 io write");
    rd(32'h130000 + 8*3, 64'd0, "R10 io zero");
    cycle('0, '0, 1, 32'h110000, 64'd2, "R4 idx0 write");
    cycle('0, '0, 1, 32'h120000, 64'hF, "R4 idx0 write");
    rd(32'h110000, 64'd0, "R4 line0 zero");
    rd(32'h120000, 64'd0, "R4 mask0 zero");

    cycle(32'h20, one_idx(5, 1), 0, 0, 0, "R5 single");
    cycle(32'h20, one_idx(5, 2), 0, 0, 0, "R5 multicast");
    cycle(32'h88, one_idx(3, 2) | one_idx(7, 2), 0, 0, 0, "R7 lowest");
    cycle(32'h88, one_idx(3, 6) | one_idx(7, 5), 0, 0, 0, "R5 two slots");
    cycle(32'h1, one_idx(0, 9), 0, 0, 0, "R2 line3 none");
    cycle(32'h1, one_idx(0, 13), 0, 0, 0, "R3 zero mask");
    cycle(32'h1, one_idx(0, 0), 0, 0, 0, "R4 idx0 source");
    cycle(32'h1, one_idx(0, 20), 0, 0, 0, "R4 out of range");
    cycle(32'h10, one_idx(4, 5), 0, 0, 0, "R8 set");
    cycle('0, '0, 0, 0, 0, "R8 clear");
    cycle(32'h10, one_idx(4, 5), 1, 32'h200000 + 8*3, 64'h8000_0000_0000_0007, "R11 dest write");
    cycle(32'h10, one_idx(4, 5), 1, 32'h110000 + 8*5, 64'd1, "R12 same edge");
    cycle(32'h10, one_idx(4, 5), 0, 0, 0, "R12 next cycle");

    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      logic w;
      p = $urandom() & $urandom();
      for (int i = 0; i < NS; i++) ix[i*IW +: IW] = IW'($urandom_range(0, 20));
      w = ($urandom_range(0, 3) == 0);
      case ($urandom_range(0, 2))
        0: a = 32'h110000 + 32'($urandom_range(0, NE-1) * 8);
        1: a = 32'h120000 + 32'($urandom_range(0, NE-1) * 32 + $urandom_range(0, 3) * 8);
        default: a = 32'h200000 + 32'($urandom_range(0, NSL-1) * 8);
      endcase
      cycle(p, ix, w, a, {$urandom(), $urandom()}, "R5 R7 R12 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule